// File: doc/BRIEF.md
# Refresh-Aware Memory Port Arbiter

This block decides who drives a DRAM command path: the core-processor transaction queue or the periodic refresh engine. A free-running interval timer raises a refresh request each time its period elapses. Requests that cannot be served at once are counted in a saturating pending counter, so none are lost while traffic holds the bus.

A core tenure is never cut short by refresh. It ends only when its programmed transaction budget is used up or when the queue runs dry. After that the bus passes through one idle cycle. If any refresh is owed at that point, refresh takes the bus and issues every owed refresh back to back. Each refresh is a single-cycle strobe, and the next strobe waits for a completion handshake. The bus is released only when the pending count is zero. Refreshes that fall due during a core tenure are therefore served together, in one refresh tenure.

Top module: `mem_refresh_arbiter`

## Requirements
- R1: With a nonzero period value P on `refresh_interval_i`, the timer raises one refresh request every P cycles. The first request comes P cycles after reset, or P cycles after the period leaves zero. Each request adds one to `ref_pending_o`, unless the same cycle also issues a refresh.
- R2: A period value of zero stops refresh generation. `ref_pending_o` never rises while the period is zero.
- R3: `ref_pending_o` saturates at 2^PEND_W-1. A request that arrives at saturation, with no issue in the same cycle, is dropped and sets `ref_overflow_o`. That flag stays at 1 until reset.
- R4: During a core tenure, the arbiter counts the cycles in which `cq_txn_done_i` is 1. The tenure ends at the edge where this count reaches `tenure_limit_i`. A limit of 0 acts as a limit of 1.
- R5: A core tenure also ends at the first edge where `cq_req_i` is 0, even if the limit has not been reached.
- R6: Refresh never preempts a core tenure. `ref_gnt_o` rises only in a cycle after one in which `cq_gnt_o` was 0.
- R7: From the idle state, a nonzero pending count wins the bus over an asserted `cq_req_i`.
- R8: While refresh holds the bus, `ref_issue_o` pulses for one cycle, and the pending count drops by one at that edge. The arbiter then waits for `ref_done_i`. If the count is still nonzero at that point, the next strobe follows at once. Otherwise the bus returns to idle.
- R9: After reset, all outputs are 0.
- R10: `cq_gnt_o` and `ref_gnt_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| refresh_interval_i | input | INT_W | Refresh period in cycles; 0 disables refresh generation |
| tenure_limit_i | input | TXN_W | Maximum number of transactions in one core tenure |
| cq_req_i | input | 1 | Core queue holds at least one transaction |
| cq_txn_done_i | input | 1 | A granted core transaction completes this cycle |
| ref_done_i | input | 1 | The refresh in progress has completed |
| cq_gnt_o | output | 1 | Core queue owns the command path |
| ref_gnt_o | output | 1 | Refresh owns the command path |
| ref_issue_o | output | 1 | One-cycle strobe that starts a refresh |
| ref_pending_o | output | PEND_W | Number of refreshes owed |
| ref_overflow_o | output | 1 | Sticky flag: a request was dropped at saturation |

## Verification
The assertions assume the following about the inputs:
- `ref_done_i` pulses only while refresh holds the bus and no strobe is active.
- `cq_txn_done_i` pulses only while the core holds the bus.
- `tenure_limit_i` changes only when no core tenure is running.

The stimulus keeps within these limits. Completion pulses are generated only in reply to the observed grant or strobe, after a configurable delay. The tenure limit is rewritten only after the queue has drained and the core grant has dropped.

// File: rtl/mra_pkg.sv
package mra_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_CQ       = 2'd1,
    ST_REF_ISS  = 2'd2,
    ST_REF_WAIT = 2'd3
  } arb_state_e;
endpackage

// File: rtl/mra_refresh_timer.sv
module mra_refresh_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] interval_i,
  output logic             tick_o
);
  logic [INT_W-1:0] cnt_q;
  logic             enabled;

  assign enabled = (interval_i != '0);
  // >= guards against a period lowered below the running count
  assign tick_o  = enabled && (cnt_q >= interval_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!enabled) cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mra_pending_ctr.sv
module mra_pending_ctr #(
  parameter int PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              ovf_o
);
  localparam logic [PEND_W-1:0] PendMax = {PEND_W{1'b1}};

  logic [PEND_W-1:0] pend_q;
  logic              ovf_q;
  logic              at_max;

  assign at_max = (pend_q == PendMax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (inc_i && !dec_i) begin
        if (at_max) ovf_q  <= 1'b1;
        else        pend_q <= pend_q + 1'b1;
      end else if (dec_i && !inc_i) begin
        pend_q <= pend_q - 1'b1;
      end
    end
  end

  assign pend_o = pend_q;
  assign ovf_o  = ovf_q;

  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (pend_q != '0));
  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max && inc_i && !dec_i) |=> (pend_q == PendMax && ovf_q));
  p_ovf_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q);
endmodule

// File: rtl/mra_arb_fsm.sv
module mra_arb_fsm
  import mra_pkg::*;
#(
  parameter int TXN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cq_req_i,
  input  logic             cq_txn_done_i,
  input  logic [TXN_W-1:0] tenure_limit_i,
  input  logic             ref_pend_i,
  input  logic             ref_done_i,
  output logic             cq_gnt_o,
  output logic             ref_gnt_o,
  output logic             ref_issue_o
);
  arb_state_e       state_q, state_d;
  logic [TXN_W-1:0] tcnt_q, tcnt_d;
  logic [TXN_W:0]   lim_eff;
  logic [TXN_W:0]   tcnt_inc;
  logic             last_txn;

  assign lim_eff  = (tenure_limit_i == '0) ? {{TXN_W{1'b0}}, 1'b1} : {1'b0, tenure_limit_i};
  assign tcnt_inc = {1'b0, tcnt_q} + 1'b1;
  assign last_txn = cq_txn_done_i && (tcnt_inc >= lim_eff);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend_i) begin
          state_d = ST_REF_ISS;
        end else if (cq_req_i) begin
          state_d = ST_CQ;
          tcnt_d  = '0;
        end
      end
      ST_CQ: begin
        if (!cq_req_i || last_txn) state_d = ST_IDLE;
        else if (cq_txn_done_i)    tcnt_d  = tcnt_q + 1'b1;
      end
      ST_REF_ISS:  state_d = ST_REF_WAIT;
      ST_REF_WAIT: begin
        if (ref_done_i) state_d = ref_pend_i ? ST_REF_ISS : ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
    end
  end

  assign cq_gnt_o    = (state_q == ST_CQ);
  assign ref_issue_o = (state_q == ST_REF_ISS);
  assign ref_gnt_o   = (state_q == ST_REF_ISS) || (state_q == ST_REF_WAIT);

  p_tenure_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cq_gnt_o |-> ({1'b0, tcnt_q} < lim_eff));
  p_no_preempt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_gnt_o) |-> !$past(cq_gnt_o));
  p_ref_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cq_gnt_o && !ref_gnt_o && ref_pend_i) |=> ref_gnt_o);
  p_strobe_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_issue_o |=> (!ref_issue_o && ref_gnt_o));
  p_drain_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_gnt_o && !ref_issue_o && ref_done_i && ref_pend_i) |=> ref_issue_o);
endmodule

// File: rtl/mem_refresh_arbiter.sv
module mem_refresh_arbiter #(
  parameter int INT_W  = 16,
  parameter int TXN_W  = 4,
  parameter int PEND_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INT_W-1:0]  refresh_interval_i,
  input  logic [TXN_W-1:0]  tenure_limit_i,
  input  logic              cq_req_i,
  input  logic              cq_txn_done_i,
  input  logic              ref_done_i,
  output logic              cq_gnt_o,
  output logic              ref_gnt_o,
  output logic              ref_issue_o,
  output logic [PEND_W-1:0] ref_pending_o,
  output logic              ref_overflow_o
);
  logic tick;
  logic pend_nz;

  mra_refresh_timer #(.INT_W(INT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .interval_i (refresh_interval_i),
    .tick_o     (tick)
  );

  mra_pending_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (ref_issue_o),
    .pend_o (ref_pending_o),
    .ovf_o  (ref_overflow_o)
  );

  assign pend_nz = (ref_pending_o != '0);

  mra_arb_fsm #(.TXN_W(TXN_W)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cq_req_i       (cq_req_i),
    .cq_txn_done_i  (cq_txn_done_i),
    .tenure_limit_i (tenure_limit_i),
    .ref_pend_i     (pend_nz),
    .ref_done_i     (ref_done_i),
    .cq_gnt_o       (cq_gnt_o),
    .ref_gnt_o      (ref_gnt_o),
    .ref_issue_o    (ref_issue_o)
  );

  p_gnt_mutex_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cq_gnt_o && ref_gnt_o));
endmodule

// File: tb/mem_refresh_arbiter_tb_top.sv
`timescale 1ns/1ps
module mem_refresh_arbiter_tb_top;
  localparam int INT_W  = 16;
  localparam int TXN_W  = 4;
  localparam int PEND_W = 4;
  localparam int PMAX   = (1 << PEND_W) - 1;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [INT_W-1:0]  interval = '0;
  logic [TXN_W-1:0]  limit = 4'd4;
  logic              cq_req = 1'b0;
  logic              txn_done = 1'b0;
  logic              ref_done = 1'b0;
  logic              cq_gnt, ref_gnt, ref_issue, ovf;
  logic [PEND_W-1:0] pend;

  always #2.5 clk = ~clk;

  mem_refresh_arbiter #(.INT_W(INT_W), .TXN_W(TXN_W), .PEND_W(PEND_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .refresh_interval_i(interval),
    .tenure_limit_i(limit), .cq_req_i(cq_req), .cq_txn_done_i(txn_done),
    .ref_done_i(ref_done), .cq_gnt_o(cq_gnt), .ref_gnt_o(ref_gnt),
    .ref_issue_o(ref_issue), .ref_pending_o(pend), .ref_overflow_o(ovf)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // behavioural reference: owner 0 idle, 1 core, 2 strobe, 3 waiting
  int m_tmr, m_pend, m_owner, m_used;
  bit m_ovf;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tmr = 0; m_pend = 0; m_ovf = 0; m_owner = 0; m_used = 0;
    end else begin
      int per, cap, old_pend;
      bit due, strobe;
      per = int'(interval);
      cap = (limit == 0) ? 1 : int'(limit);
      due = (per != 0) && (m_tmr + 1 >= per);
      strobe = (m_owner == 2);
      old_pend = m_pend;
      m_tmr = (per == 0 || due) ? 0 : m_tmr + 1;
      if (due && !strobe) begin
        if (m_pend == PMAX) m_ovf = 1; else m_pend++;
      end else if (strobe && !due) m_pend--;
      case (m_owner)
        0: if (old_pend != 0) m_owner = 2;
           else if (cq_req) begin m_owner = 1; m_used = 0; end
        1: if (!cq_req) m_owner = 0;
           else if (txn_done) begin
             if (m_used + 1 >= cap) m_owner = 0; else m_used++;
           end
        2: m_owner = 3;
        default: if (ref_done) m_owner = (old_pend != 0) ? 2 : 0;
      endcase
    end
  end

  // stimulus state
  int q_left = 0, q_add = 0, txn_gap = 1, done_dly = 1, dcnt = 0, cyc = 0;
  bit txn_pending = 0, cmp_on = 0;
  int max_pend_in_cq = 0;

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      chk(cq_gnt == (m_owner == 1), "R4 R5 R7 cq_gnt", int'(cq_gnt), int'(m_owner == 1));
      chk(ref_gnt == (m_owner >= 2), "R8 ref_gnt", int'(ref_gnt), int'(m_owner >= 2));
      chk(ref_issue == (m_owner == 2), "R8 ref_issue", int'(ref_issue), int'(m_owner == 2));
      chk(int'(pend) == m_pend, "R1 R2 R3 pending", int'(pend), m_pend);
      chk(ovf == m_ovf, "R3 overflow", int'(ovf), int'(m_ovf));
      chk(!(cq_gnt && ref_gnt), "R10 grant overlap", int'(cq_gnt && ref_gnt), 0);
      if (cq_gnt && int'(pend) > max_pend_in_cq) max_pend_in_cq = int'(pend);
    end
    if (txn_pending) q_left--;
    txn_pending = 0;
    q_left += q_add;
    q_add = 0;
    cq_req <= (q_left > 0);
    if (cq_gnt && q_left > 0 && (cyc % txn_gap) == 0) begin
      txn_done <= 1'b1;
      txn_pending = 1;
    end else txn_done <= 1'b0;
    ref_done <= 1'b0;
    if (ref_issue) dcnt = done_dly;
    else if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) ref_done <= 1'b1;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic scenario();
    // R9 reset values
    #1;
    chk(!cq_gnt && !ref_gnt && !ref_issue && pend == 0 && !ovf, "R9 reset outputs",
        int'({cq_gnt, ref_gnt, ref_issue, ovf}) + int'(pend), 0);
    step(3);
    rst_ni = 1'b1;
    cmp_on = 1;
    // R2 no refresh while period is zero
    step(40);
    chk(pend == 0, "R2 pending with zero period", int'(pend), 0);
    // R4 R5 core alone, budget 4
    limit = 4'd4; txn_gap = 2; q_add = 10;
    step(80);
    chk(q_left == 0 && !cq_gnt, "R5 queue drained", q_left, 0);
    // R4 limit zero acts as one
    limit = 4'd0; q_add = 3;
    step(30);
    chk(q_left == 0, "R4 zero limit drained", q_left, 0);
    // R6 R7 refresh piles up under a long tenure
    limit = 4'd8; txn_gap = 5; done_dly = 2; interval = 16'd7;
    q_add = 20; max_pend_in_cq = 0;
    step(2);
    begin
      int guard = 0;
      while (!cq_gnt && guard < 100) begin step(1); guard++; end
      while (cq_gnt && guard < 400) begin step(1); guard++; end
    end
    // cq_gnt just fell: one idle cycle, then refresh must own the bus
    step(1);
    chk(ref_gnt && !cq_gnt, "R7 refresh wins idle bus", int'(ref_gnt), 1);
    chk(max_pend_in_cq >= 2, "R6 refreshes held during tenure", max_pend_in_cq, 2);
    step(250);
    chk(q_left == 0, "R6 core traffic resumed", q_left, 0);
    // R3 saturation
    interval = 16'd3; done_dly = 20;
    step(250);
    chk(ovf == 1'b1, "R3 overflow set", int'(ovf), 1);
    chk(int'(pend) == PMAX, "R3 pending saturated", int'(pend), PMAX);
    // R8 drain to zero with generation stopped
    interval = 16'd0;
    step(600);
    chk(pend == 0 && !ref_gnt, "R8 drained and released", int'(pend), 0);
    chk(ovf == 1'b1, "R3 overflow sticky", int'(ovf), 1);
    // R1 fresh period after re-enable
    interval = 16'd50; done_dly = 1;
    step(49);
    chk(pend == 0, "R1 no request before period", int'(pend), 0);
    step(1);
    chk(pend == 1, "R1 request after period", int'(pend), 1);
    limit = 4'd2; txn_gap = 1; q_add = 5;
    step(60);
    chk(q_left == 0, "R4 short budget drained", q_left, 0);
  endtask

  initial begin
    fork
      scenario();
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R9 watchdog expired: actual %0d expected 0", 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule